// File: doc/BRIEF.md
# Push-Button Conditioner with Long-Hold Override

This block conditions two active-low push-button inputs: a power button and a sleep button. Each raw input first passes through a two-flop synchroniser. It is then debounced, which means the conditioned level follows the input only after the input has stayed steady for a full stability window. Debouncing works the same way for presses and for releases. A free-running divider turns the 1 ms tick input into 4 ms slots, and the window is counted in these slots. The window is four slots, so a steady input is accepted after 12 to 16 ms. For the sleep button, an extra-debounce option doubles the window to eight slots. When a conditioned level becomes active, the block raises a one-cycle press pulse.

While a conditioned level is active, a hold timer counts milliseconds. When the hold passes four seconds, the block raises a one-cycle override pulse and a one-cycle clear pulse for that button's pending press status. The override fires once per hold, and the timer rearms only after the button is released. Each button has its own override-disable input. The sleep button also has a function-select input: when it is low, the sleep button produces neither press nor override events. The status register and the power-state sequencing that consume these pulses sit outside this block.

Top module: `btn_conditioner`

## Requirements
- R1: After synchronous reset both conditioned levels read 0 (released) and no press, clear or override pulse is high.
- R2: An input driven low and then held steady makes its conditioned level go to 1. This happens no earlier than 12 ms and no later than 19 ms after the input change, the two synchroniser cycles included.
- R3: A release is debounced with the same window: after the input returns high and stays high, the level goes to 0 between 12 ms and 19 ms later.
- R4: Any low excursion that lasts no more than 11 ms before the input returns high leaves the conditioned level at 0 and produces no press.
- R5: With sleep extra debounce set, the sleep window doubles. The sleep level does not change within 23 ms of an input change and has changed by 37 ms.
- R6: A press pulse lasts exactly one cycle. It is raised on the same clock edge on which the level becomes 1, and a release raises no pulse.
- R7: With the sleep function not selected, the sleep level still follows the input, but no sleep press, sleep clear or override comes from the sleep button.
- R8: With the power-button override enabled, the block pulses both power clear and override for one cycle. This happens 4001 ms ticks after the power level became 1, exactly once per hold. A hold released before 4000 ms produces neither pulse, and a new hold after a release fires again.
- R9: With the power override disable high, holding the power button produces neither power clear nor override.
- R10: With the sleep function selected and the sleep override disable low, a sleep hold of more than four seconds pulses sleep clear and override once, 4001 ticks after the sleep level rises. With the sleep override disable high, it pulses neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| pwr_btn_n | input | 1 | Raw power button, active low, asynchronous |
| slp_btn_n | input | 1 | Raw sleep button, active low, asynchronous |
| slp_fn_sel | input | 1 | 1 = the pin acts as a sleep button |
| slp_extra_db | input | 1 | 1 = double the sleep debounce window |
| pwr_ovr_dis | input | 1 | 1 = no power override |
| slp_ovr_dis | input | 1 | 1 = no sleep override |
| pwr_level | output | 1 | Debounced power button, 1 = pressed |
| slp_level | output | 1 | Debounced sleep button, 1 = pressed |
| pwr_press | output | 1 | One-cycle power press event |
| slp_press | output | 1 | One-cycle sleep press event |
| pwr_clr | output | 1 | One-cycle clear of the power press status |
| slp_clr | output | 1 | One-cycle clear of the sleep press status |
| ovr_event | output | 1 | One-cycle override event from either button |

## Verification
The checker watches the following on every cycle:
- Press and clear pulses last a single cycle.
- A press pulse coincides with a rising conditioned level.
- Sleep events never appear while the function is deselected.
- A clear pulse comes only from an enabled button that is still held.

The timing windows can only be shown by the bench's scenarios. These are the 12 to 19 ms acceptance, the doubled sleep window and the exact 4001-tick override delay. The same holds for the glitch-length sweep, for once-per-hold firing and for rearming after release.

// File: rtl/btn_cond_pkg.sv
package btn_cond_pkg;
  localparam int unsigned DEF_SLOT_MS  = 4;
  localparam int unsigned DEF_DB_SLOTS = 4;
  localparam int unsigned DEF_HOLD_MS  = 4000;

  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/btn_sync.sv
module btn_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din_n,
  output logic [W-1:0] dout_n
);
  logic [W-1:0] stage1, stage2;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '1;
      stage2 <= '1;
    end else begin
      stage1 <= din_n;
      stage2 <= stage1;
    end
  end

  assign dout_n = stage2;
endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned DB_SLOTS = btn_cond_pkg::DEF_DB_SLOTS
) (
  input  logic clk,
  input  logic rst,
  input  logic slot,
  input  logic dbl,
  input  logic evt_en,
  input  logic sync_n,
  output logic level,
  output logic rise
);
  localparam int unsigned MAXW = 2 * DB_SLOTS;
  localparam int unsigned CW   = btn_cond_pkg::cnt_width(MAXW);

  logic [CW-1:0] cnt;
  logic [CW-1:0] last;
  logic          raw_act;

  assign raw_act = ~sync_n;
  assign last    = dbl ? CW'(MAXW - 1) : CW'(DB_SLOTS - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      level <= 1'b0;
      rise  <= 1'b0;
      cnt   <= '0;
    end else begin
      rise <= 1'b0;
      if (raw_act == level) begin
        cnt <= '0;
      end else if (slot) begin
        if (cnt >= last) begin
          level <= raw_act;
          rise  <= raw_act & evt_en;
          cnt   <= '0;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/btn_hold_timer.sv
module btn_hold_timer #(
  parameter int unsigned HOLD_MS = btn_cond_pkg::DEF_HOLD_MS
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic level,
  input  logic arm,
  output logic fire
);
  localparam int unsigned CAP = HOLD_MS + 1;
  localparam int unsigned CW  = btn_cond_pkg::cnt_width(CAP);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      fire <= 1'b0;
    end else begin
      fire <= 1'b0;
      if (!level) begin
        cnt <= '0;
      end else if (tick && cnt != CW'(CAP)) begin
        cnt  <= cnt + 1'b1;
        fire <= arm && (cnt == CW'(HOLD_MS));
      end
    end
  end
endmodule

// File: rtl/btn_conditioner.sv
module btn_conditioner #(
  parameter int unsigned SLOT_MS  = btn_cond_pkg::DEF_SLOT_MS,
  parameter int unsigned DB_SLOTS = btn_cond_pkg::DEF_DB_SLOTS,
  parameter int unsigned HOLD_MS  = btn_cond_pkg::DEF_HOLD_MS
) (
  input  logic clk,
  input  logic rst,
  input  logic ms_tick,
  input  logic pwr_btn_n,
  input  logic slp_btn_n,
  input  logic slp_fn_sel,
  input  logic slp_extra_db,
  input  logic pwr_ovr_dis,
  input  logic slp_ovr_dis,
  output logic pwr_level,
  output logic slp_level,
  output logic pwr_press,
  output logic slp_press,
  output logic pwr_clr,
  output logic slp_clr,
  output logic ovr_event
);
  localparam int unsigned PW = btn_cond_pkg::cnt_width(SLOT_MS - 1);

  logic [PW-1:0] pre;
  logic          slot;
  logic [1:0]    sync_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
    end else if (ms_tick) begin
      pre <= (pre == PW'(SLOT_MS - 1)) ? '0 : pre + 1'b1;
    end
  end
  assign slot = ms_tick && (pre == PW'(SLOT_MS - 1));

  btn_sync #(.W(2)) u_sync (
    .clk(clk), .rst(rst),
    .din_n({slp_btn_n, pwr_btn_n}),
    .dout_n(sync_n)
  );

  btn_debounce #(.DB_SLOTS(DB_SLOTS)) u_db_pwr (
    .clk(clk), .rst(rst), .slot(slot), .dbl(1'b0), .evt_en(1'b1),
    .sync_n(sync_n[0]), .level(pwr_level), .rise(pwr_press)
  );

  btn_debounce #(.DB_SLOTS(DB_SLOTS)) u_db_slp (
    .clk(clk), .rst(rst), .slot(slot), .dbl(slp_extra_db), .evt_en(slp_fn_sel),
    .sync_n(sync_n[1]), .level(slp_level), .rise(slp_press)
  );

  btn_hold_timer #(.HOLD_MS(HOLD_MS)) u_hold_pwr (
    .clk(clk), .rst(rst), .tick(ms_tick), .level(pwr_level),
    .arm(!pwr_ovr_dis), .fire(pwr_clr)
  );

  btn_hold_timer #(.HOLD_MS(HOLD_MS)) u_hold_slp (
    .clk(clk), .rst(rst), .tick(ms_tick), .level(slp_level),
    .arm(slp_fn_sel && !slp_ovr_dis), .fire(slp_clr)
  );

  assign ovr_event = pwr_clr | slp_clr;
endmodule

// File: rtl/btn_conditioner_chk.sv
module btn_conditioner_chk (
  input logic clk,
  input logic rst,
  input logic slp_fn_sel,
  input logic pwr_ovr_dis,
  input logic slp_ovr_dis,
  input logic pwr_level,
  input logic slp_level,
  input logic pwr_press,
  input logic slp_press,
  input logic pwr_clr,
  input logic slp_clr,
  input logic ovr_event
);
  // R6
  pwr_press_single_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_press |=> !pwr_press);
  // R6
  pwr_press_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_press |-> (pwr_level && !$past(pwr_level)));
  // R6
  slp_press_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
    slp_press |-> (slp_level && !$past(slp_level)));
  // R7
  slp_press_needs_fn_chk: assert property (@(posedge clk) disable iff (rst)
    slp_press |-> $past(slp_fn_sel));
  // R8
  pwr_clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_clr |=> !pwr_clr);
  // R8
  pwr_clr_held_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_clr |-> ($past(pwr_level) && ovr_event));
  // R9
  pwr_clr_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    pwr_clr |-> !$past(pwr_ovr_dis));
  // R10
  slp_clr_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    slp_clr |-> ($past(slp_fn_sel) && !$past(slp_ovr_dis) && $past(slp_level)));
  // R10
  slp_clr_single_chk: assert property (@(posedge clk) disable iff (rst)
    slp_clr |=> !slp_clr);
endmodule

bind btn_conditioner btn_conditioner_chk i_chk (
  .clk(clk), .rst(rst), .slp_fn_sel(slp_fn_sel), .pwr_ovr_dis(pwr_ovr_dis),
  .slp_ovr_dis(slp_ovr_dis), .pwr_level(pwr_level), .slp_level(slp_level),
  .pwr_press(pwr_press), .slp_press(slp_press), .pwr_clr(pwr_clr),
  .slp_clr(slp_clr), .ovr_event(ovr_event)
);

// File: tb/test_btn_conditioner.sv
module test_btn_conditioner;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 4000;

  logic clk = 0, rst = 1, ms_tick = 1;
  logic pwr_btn_n = 1, slp_btn_n = 1, slp_fn_sel = 1, slp_extra_db = 0;
  logic pwr_ovr_dis = 0, slp_ovr_dis = 0;
  logic pwr_level, slp_level, pwr_press, slp_press, pwr_clr, slp_clr, ovr_event;

  int n_chk = 0, n_bad = 0;
  int cyc = 0;
  int n_pp = 0, n_sp = 0, n_pc = 0, n_sc = 0, n_ov = 0;
  int t_pp = 0, t_sp = 0, t_pc = 0, t_sc = 0, t_ov = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btn_conditioner i_btn_conditioner (
    .clk(clk), .rst(rst), .ms_tick(ms_tick), .pwr_btn_n(pwr_btn_n),
    .slp_btn_n(slp_btn_n), .slp_fn_sel(slp_fn_sel), .slp_extra_db(slp_extra_db),
    .pwr_ovr_dis(pwr_ovr_dis), .slp_ovr_dis(slp_ovr_dis),
    .pwr_level(pwr_level), .slp_level(slp_level), .pwr_press(pwr_press),
    .slp_press(slp_press), .pwr_clr(pwr_clr), .slp_clr(slp_clr),
    .ovr_event(ovr_event)
  );

  always @(posedge clk) begin
    #1;
    cyc++;
    if (!rst) begin
      if (pwr_press) begin n_pp++; t_pp = cyc; end
      if (slp_press) begin n_sp++; t_sp = cyc; end
      if (pwr_clr)   begin n_pc++; t_pc = cyc; end
      if (slp_clr)   begin n_sc++; t_sc = cyc; end
      if (ovr_event) begin n_ov++; t_ov = cyc; end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_counts();
    n_pp = 0; n_sp = 0; n_pc = 0; n_sc = 0; n_ov = 0;
  endtask

  // power press, long hold, release; expected override exactly HOLD+1 ticks after press
  task automatic pwr_hold(input int hold_cyc, input int exp_ovr, input string req);
    clear_counts();
    pwr_btn_n = 0;
    wait_cyc(11);
    check("R2 pwr level early", int'(pwr_level), 0);
    wait_cyc(10);
    check("R2 pwr level accepted", int'(pwr_level), 1);
    check("R6 pwr press count", n_pp, 1);
    wait_cyc(hold_cyc);
    check({req, " pwr clr count"}, n_pc, exp_ovr);
    check({req, " ovr count"}, n_ov, exp_ovr);
    if (exp_ovr == 1) begin
      check("R8 pwr clr delay", t_pc - t_pp, HOLD + 1);
      check("R8 ovr with clr", t_ov, t_pc);
    end
    pwr_btn_n = 1;
    wait_cyc(11);
    check("R3 pwr release early", int'(pwr_level), 1);
    wait_cyc(10);
    check("R3 pwr released", int'(pwr_level), 0);
    check("R6 no release pulse", n_pp, 1);
  endtask

  task automatic slp_hold(input int exp_press, input int exp_ovr, input string req);
    clear_counts();
    slp_btn_n = 0;
    wait_cyc(11);
    check("R2 slp level early", int'(slp_level), 0);
    wait_cyc(10);
    check("R2 slp level accepted", int'(slp_level), 1);
    check({req, " slp press count"}, n_sp, exp_press);
    wait_cyc(HOLD + 100);
    check({req, " slp clr count"}, n_sc, exp_ovr);
    check({req, " ovr count"}, n_ov, exp_ovr);
    check({req, " no pwr clr"}, n_pc, 0);
    if (exp_ovr == 1) check("R10 slp clr delay", t_sc - t_sp, HOLD + 1);
    slp_btn_n = 1;
    wait_cyc(21);
    check("R3 slp released", int'(slp_level), 0);
  endtask

  initial begin
    wait_cyc(4);
    rst = 0;
    @(negedge clk);
    // R1
    check("R1 pwr level", int'(pwr_level), 0);
    check("R1 slp level", int'(slp_level), 0);
    check("R1 pulses", int'({pwr_press, slp_press, pwr_clr, slp_clr, ovr_event}), 0);

    // R8 override, then rearm on a second hold
    pwr_hold(HOLD + 100, 1, "R8");
    pwr_hold(HOLD + 100, 1, "R8 rearm");
    // R8 short hold
    pwr_hold(HOLD - 100, 0, "R8 short");
    // R9 disabled override
    pwr_ovr_dis = 1;
    pwr_hold(HOLD + 100, 0, "R9");
    pwr_ovr_dis = 0;

    // R4 glitch-length sweep on both buttons
    for (int len = 1; len <= 11; len++) begin
      clear_counts();
      pwr_btn_n = 0; slp_btn_n = 0;
      wait_cyc(len);
      pwr_btn_n = 1; slp_btn_n = 1;
      wait_cyc(25);
      check("R4 glitch pwr press", n_pp, 0);
      check("R4 glitch slp press", n_sp, 0);
      check("R4 glitch level", int'({pwr_level, slp_level}), 0);
    end
    // R4 bouncing train of short lows separated by single highs
    clear_counts();
    for (int k = 0; k < 6; k++) begin
      pwr_btn_n = 0; wait_cyc(8);
      pwr_btn_n = 1; wait_cyc(1);
    end
    wait_cyc(25);
    check("R4 bounce train level", int'(pwr_level), 0);
    check("R4 bounce train press", n_pp, 0);

    // R10 sleep override enabled
    slp_hold(1, 1, "R10");
    // R10 sleep override disabled
    slp_ovr_dis = 1;
    slp_hold(1, 0, "R10 dis");
    slp_ovr_dis = 0;
    // R7 sleep function deselected
    slp_fn_sel = 0;
    slp_hold(0, 0, "R7");
    slp_fn_sel = 1;

    // R5 doubled sleep window
    slp_extra_db = 1;
    clear_counts();
    slp_btn_n = 0;
    wait_cyc(23);
    check("R5 slp early", int'(slp_level), 0);
    wait_cyc(14);
    check("R5 slp accepted", int'(slp_level), 1);
    check("R5 slp press", n_sp, 1);
    slp_btn_n = 1;
    wait_cyc(23);
    check("R5 slp release early", int'(slp_level), 1);
    wait_cyc(14);
    check("R5 slp released", int'(slp_level), 0);
    // R5 a 20 ms glitch is absorbed only when doubled
    clear_counts();
    slp_btn_n = 0; wait_cyc(20); slp_btn_n = 1;
    wait_cyc(40);
    check("R5 doubled glitch press", n_sp, 0);
    slp_extra_db = 0;
    clear_counts();
    slp_btn_n = 0; wait_cyc(20); slp_btn_n = 1;
    wait_cyc(40);
    check("R5 single window accepts 20 ms", n_sp, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait_cyc(150000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule